// File: doc/BRIEF.md
# Register Window Trap Sequencer

This block is the control half of a windowed register file. It holds the current window pointer, an eight-bit mask of windows that may not be entered, a trap-enable flag and a sticky error-halt flag. Each cycle it takes at most one event from five sources: a save, a restore, a return-from-trap, a synchronous fault or an external interrupt. It then rotates the window, enters a trap, or halts. When it enters a trap it always moves one window down and does not look at the mask. It also clears trap-enable and emits a one-cycle strobe together with a handler address.

A save or restore whose target window is masked does not rotate. It turns into an overflow or underflow trap, which is entered like any other trap. A synchronous trap that arrives while traps are disabled cannot be taken safely. The block then latches an error halt and freezes until reset. Interrupts are only held off while traps are disabled. A combinational address map turns a logical register number and the window pointer into a physical register index. Adjacent windows share eight registers through this map.

Top module: `winTrapSeq`

## Requirements
- R1: After synchronous reset the window pointer is 0, the mask is 0x02, trap-enable is 0, error halt is 0 and the trap strobe is low.
- R2: When the target window's mask bit is clear, a save moves the pointer to (pointer-1) mod 8 and a restore moves it to (pointer+1) mod 8. This holds whatever the state of trap-enable. The mask test uses the value held before any mask write in the same cycle.
- R3: A save into a masked window does not rotate and raises trap type 0x05. A restore into a masked window does not rotate and raises trap type 0x06.
- R4: Trap entry sets the pointer to (pointer-1) mod 8 even when that window is masked. It clears trap-enable and raises the trap strobe for exactly one cycle. The vector output becomes {base, trap type, 4'b0000}.
- R5: When trap-enable is 1 and no synchronous request is present, an interrupt is taken with trap type 0x10 plus the 4-bit level. When trap-enable is 0, an interrupt is ignored and never causes a halt.
- R6: A fault taken with trap-enable at 1 uses its own 8-bit type as the trap type. The priority is fault, then save, then restore, then return-from-trap, then interrupt, and only one event is acted on per cycle.
- R7: A fault, or a save or restore aimed at a masked window, that arrives while trap-enable is 0 sets the error halt. No trap is taken and the pointer does not change.
- R8: While error halt is set, the pointer, mask and trap-enable are frozen, no trap strobe is produced, and only reset clears the halt.
- R9: A return-from-trap performs a restore-direction rotation with the mask test and sets trap-enable in the same cycle. If the target is masked, it behaves as a restore into a masked window.
- R10: Logical registers 0-7 map to physical indices 0-7. For logical register r with 8 ≤ r ≤ 31, group g = r/8 gives an offset of 0 for g=1, 8 for g=2 and 16 for g=3. The physical index is 8 + ((16·pointer + offset + r mod 8) mod 128). As a result, register 24+k in window w-1 equals register 8+k in window w.
- R11: A mask write replaces the whole mask at the next clock edge unless error halt is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| saveReq | input | 1 | Save request (rotate down) |
| restoreReq | input | 1 | Restore request (rotate up) |
| rettReq | input | 1 | Return-from-trap: restore rotation plus trap enable |
| irqReq | input | 1 | External interrupt request |
| irqLevel | input | 4 | Interrupt level |
| faultReq | input | 1 | Synchronous fault request |
| faultType | input | 8 | Trap type of the fault |
| maskWrite | input | 1 | Load the invalid mask |
| maskData | input | 8 | New invalid mask value |
| logReg | input | 5 | Logical register number to map |
| curWin | output | 3 | Current window pointer |
| invMask | output | 8 | Window-invalid mask |
| trapEnable | output | 1 | Trap-enable flag |
| trapTaken | output | 1 | One-cycle trap entry strobe |
| trapVector | output | 32 | Handler address of the last trap |
| errorHalt | output | 1 | Sticky error halt |
| physIdx | output | 8 | Physical register index for logReg |

## Verification
The hardest state to reach is a window trap that must itself rotate into a masked window. This happens when a save overflows at pointer 0 with window 7 masked, so trap entry has to wrap and ignore the mask in the same cycle. The stimulus gets there through return-from-trap and a series of saves that walk the pointer around the ring, with mask writes placed in the same cycles as returns so that the old-mask rule is exercised along the way. Error halt is reached in two ways: by a fault after an interrupt has disabled traps, and by a masked restore straight after reset. The frozen state is then probed with every request at once.

// File: rtl/winTrapPkg.sv
package winTrapPkg;

  localparam int TT_W = 8;

  localparam logic [TT_W-1:0] TT_OVERFLOW  = 8'h05;
  localparam logic [TT_W-1:0] TT_UNDERFLOW = 8'h06;
  localparam logic [TT_W-1:0] TT_IRQ_BASE  = 8'h10;

  // Strobes from the decision logic to the state registers
  typedef struct packed {
    logic            rotDown;
    logic            rotUp;
    logic            setEt;
    logic            takeTrap;
    logic            setHalt;
    logic [TT_W-1:0] trapType;
  } ctrlStrobe_t;

endpackage

// File: rtl/winTrapCtrl.sv
module winTrapCtrl
  import winTrapPkg::*;
#(
  parameter int NWIN  = 8,
  parameter int PTR_W = $clog2(NWIN)
) (
  input  logic             saveReq,
  input  logic             restoreReq,
  input  logic             rettReq,
  input  logic             irqReq,
  input  logic [3:0]       irqLevel,
  input  logic             faultReq,
  input  logic [TT_W-1:0]  faultType,
  input  logic [PTR_W-1:0] curWin,
  input  logic [NWIN-1:0]  invMask,
  input  logic             trapEnable,
  input  logic             halted,
  output ctrlStrobe_t      strb
);

  localparam logic [PTR_W-1:0] ONE = PTR_W'(1);

  logic [PTR_W-1:0] upWin;
  logic [PTR_W-1:0] downWin;
  logic             syncTrap;
  logic [TT_W-1:0]  syncType;

  assign upWin   = curWin + ONE;
  assign downWin = curWin - ONE;

  always_comb begin
    strb     = '0;
    syncTrap = 1'b0;
    syncType = '0;
    if (!halted) begin
      if (faultReq) begin
        syncTrap = 1'b1;
        syncType = faultType;
      end else if (saveReq) begin
        if (invMask[downWin]) begin
          syncTrap = 1'b1;
          syncType = TT_OVERFLOW;
        end else begin
          strb.rotDown = 1'b1;
        end
      end else if (restoreReq || rettReq) begin
        if (invMask[upWin]) begin
          syncTrap = 1'b1;
          syncType = TT_UNDERFLOW;
        end else begin
          strb.rotUp = 1'b1;
          strb.setEt = !restoreReq;
        end
      end else if (irqReq && trapEnable) begin
        strb.takeTrap = 1'b1;
        strb.trapType = TT_IRQ_BASE + TT_W'(irqLevel);
      end

      if (syncTrap) begin
        if (trapEnable) begin
          strb.takeTrap = 1'b1;
          strb.trapType = syncType;
        end else begin
          strb.setHalt = 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/winTrapDatapath.sv
module winTrapDatapath
  import winTrapPkg::*;
#(
  parameter int              NWIN   = 8,
  parameter int              PTR_W  = $clog2(NWIN),
  parameter int              BASE_W = 20,
  parameter logic [BASE_W-1:0] VEC_BASE = '0,
  parameter int              VEC_W  = BASE_W + TT_W + 4,
  parameter logic [NWIN-1:0] MASK_RST = NWIN'(2)
) (
  input  logic             clk,
  input  logic             rst,
  input  ctrlStrobe_t      strb,
  input  logic             maskWrite,
  input  logic [NWIN-1:0]  maskData,
  output logic [PTR_W-1:0] curWin,
  output logic [NWIN-1:0]  invMask,
  output logic             trapEnable,
  output logic             trapTaken,
  output logic [VEC_W-1:0] trapVector,
  output logic             errorHalt
);

  localparam logic [PTR_W-1:0] ONE = PTR_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      curWin     <= '0;
      invMask    <= MASK_RST;
      trapEnable <= 1'b0;
      trapTaken  <= 1'b0;
      trapVector <= '0;
      errorHalt  <= 1'b0;
    end else begin
      trapTaken <= 1'b0;
      if (!errorHalt) begin
        if (maskWrite) invMask <= maskData;
        if (strb.takeTrap) begin
          curWin     <= curWin - ONE;
          trapEnable <= 1'b0;
          trapTaken  <= 1'b1;
          trapVector <= {VEC_BASE, strb.trapType, 4'h0};
        end else begin
          if (strb.rotDown) curWin <= curWin - ONE;
          if (strb.rotUp)   curWin <= curWin + ONE;
          if (strb.setEt)   trapEnable <= 1'b1;
          if (strb.setHalt) errorHalt <= 1'b1;
        end
      end
    end
  end

  AST_TRAP_ENTRY: assert property (@(posedge clk) disable iff (rst)
    strb.takeTrap |=> (curWin == $past(curWin) - ONE) && !trapEnable && trapTaken); // R4
  AST_SAVE_TARGET_VALID: assert property (@(posedge clk) disable iff (rst)
    strb.rotDown |-> !invMask[curWin - ONE]); // R2
  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (rst)
    errorHalt |=> errorHalt); // R8
  AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (rst)
    errorHalt |=> $stable(curWin) && $stable(trapEnable) && $stable(invMask) && !trapTaken); // R8
  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strb.rotDown, strb.rotUp, strb.takeTrap, strb.setHalt})); // R6
  AST_HALT_NO_MOVE: assert property (@(posedge clk) disable iff (rst)
    strb.setHalt |=> errorHalt && $stable(curWin) && !trapTaken); // R7

endmodule

// File: rtl/winRegMap.sv
module winRegMap #(
  parameter int NWIN   = 8,
  parameter int PTR_W  = $clog2(NWIN),
  parameter int PHYS_W = $clog2(8 + NWIN * 16)
) (
  input  logic [PTR_W-1:0]  curWin,
  input  logic [4:0]        logReg,
  output logic [PHYS_W-1:0] physIdx
);

  localparam int RING_W = PTR_W + 4;

  logic [1:0]        group;
  logic [RING_W-1:0] winOff;
  logic [RING_W-1:0] ringPos;

  assign group = logReg[4:3];

  always_comb begin
    case (group)
      2'd2:    winOff = RING_W'(8);
      2'd3:    winOff = RING_W'(16);
      default: winOff = '0;
    endcase
    ringPos = {curWin, 4'h0} + winOff + RING_W'(logReg[2:0]);
    if (group == 2'd0) physIdx = PHYS_W'(logReg);
    else               physIdx = PHYS_W'(8) + PHYS_W'(ringPos);
  end

endmodule

// File: rtl/winTrapSeq.sv
module winTrapSeq
  import winTrapPkg::*;
#(
  parameter int                NWIN     = 8,
  parameter int                BASE_W   = 20,
  parameter logic [BASE_W-1:0] VEC_BASE = 20'h00010,
  parameter int                PTR_W    = $clog2(NWIN),
  parameter int                VEC_W    = BASE_W + TT_W + 4,
  parameter int                PHYS_W   = $clog2(8 + NWIN * 16)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              saveReq,
  input  logic              restoreReq,
  input  logic              rettReq,
  input  logic              irqReq,
  input  logic [3:0]        irqLevel,
  input  logic              faultReq,
  input  logic [TT_W-1:0]   faultType,
  input  logic              maskWrite,
  input  logic [NWIN-1:0]   maskData,
  input  logic [4:0]        logReg,
  output logic [PTR_W-1:0]  curWin,
  output logic [NWIN-1:0]   invMask,
  output logic              trapEnable,
  output logic              trapTaken,
  output logic [VEC_W-1:0]  trapVector,
  output logic              errorHalt,
  output logic [PHYS_W-1:0] physIdx
);

  ctrlStrobe_t strb;

  winTrapCtrl #(.NWIN(NWIN), .PTR_W(PTR_W)) uCtrl (
    .saveReq(saveReq), .restoreReq(restoreReq), .rettReq(rettReq),
    .irqReq(irqReq), .irqLevel(irqLevel),
    .faultReq(faultReq), .faultType(faultType),
    .curWin(curWin), .invMask(invMask), .trapEnable(trapEnable),
    .halted(errorHalt), .strb(strb)
  );

  winTrapDatapath #(
    .NWIN(NWIN), .PTR_W(PTR_W), .BASE_W(BASE_W), .VEC_BASE(VEC_BASE), .VEC_W(VEC_W)
  ) uData (
    .clk(clk), .rst(rst), .strb(strb),
    .maskWrite(maskWrite), .maskData(maskData),
    .curWin(curWin), .invMask(invMask), .trapEnable(trapEnable),
    .trapTaken(trapTaken), .trapVector(trapVector), .errorHalt(errorHalt)
  );

  winRegMap #(.NWIN(NWIN), .PTR_W(PTR_W), .PHYS_W(PHYS_W)) uMap (
    .curWin(curWin), .logReg(logReg), .physIdx(physIdx)
  );

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
    (!trapEnable && !faultReq && !saveReq && !restoreReq && !rettReq) |=> !trapTaken); // R5
  AST_FAULT_ENABLED: assert property (@(posedge clk) disable iff (rst)
    (faultReq && trapEnable && !errorHalt) |=> trapTaken && !errorHalt); // R6
  AST_FAULT_DISABLED: assert property (@(posedge clk) disable iff (rst)
    (faultReq && !trapEnable) |=> errorHalt && !trapTaken); // R7

endmodule

// File: tb/tb_winTrapSeq.sv
`timescale 1ns/1ps
module tb_winTrapSeq;

  localparam logic [19:0] BASE = 20'h4C1A0;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic saveReq = 0, restoreReq = 0, rettReq = 0, irqReq = 0, faultReq = 0, maskWrite = 0;
  logic [3:0] irqLevel = 0;
  logic [7:0] faultType = 0, maskData = 0;
  logic [4:0] logReg = 0;
  logic [2:0] curWin;
  logic [7:0] invMask;
  logic trapEnable, trapTaken, errorHalt;
  logic [31:0] trapVector;
  logic [7:0] physIdx;

  int nTests = 0;
  int nFail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  winTrapSeq #(.VEC_BASE(BASE)) dut (
    .clk(clk), .rst(rst), .saveReq(saveReq), .restoreReq(restoreReq), .rettReq(rettReq),
    .irqReq(irqReq), .irqLevel(irqLevel), .faultReq(faultReq), .faultType(faultType),
    .maskWrite(maskWrite), .maskData(maskData), .logReg(logReg),
    .curWin(curWin), .invMask(invMask), .trapEnable(trapEnable), .trapTaken(trapTaken),
    .trapVector(trapVector), .errorHalt(errorHalt), .physIdx(physIdx)
  );

  typedef struct packed {
    logic sv, rs, rt, irq;
    logic [3:0] lvl;
    logic flt;
    logic [7:0] ft;
    logic we;
    logic [7:0] wd;
    logic [2:0] eWin;
    logic [7:0] eMask;
    logic eEt, eTk;
    logic [7:0] eTt;
    logic eHalt;
    logic [3:0] req;
  } vec_t;

  // sv rs rt irq lvl flt ft we wd | win mask et tk tt halt req
  localparam vec_t TABLE [26] = '{
    '{0,0,0,0,4'd0,0,8'h00,1,8'h00, 3'd0,8'h00,0,0,8'h00,0,4'd11}, // R11
    '{0,0,1,0,4'd0,0,8'h00,0,8'h00, 3'd1,8'h00,1,0,8'h00,0,4'd9},  // R9
    '{0,0,0,0,4'd0,0,8'h00,1,8'h01, 3'd1,8'h01,1,0,8'h00,0,4'd11},
    '{1,0,0,0,4'd0,0,8'h00,0,8'h00, 3'd0,8'h01,0,1,8'h05,0,4'd3},  // R3
    '{0,0,0,0,4'd0,0,8'h00,0,8'h00, 3'd0,8'h01,0,0,8'h00,0,4'd4},  // R4 pulse
    '{0,0,0,1,4'd3,0,8'h00,0,8'h00, 3'd0,8'h01,0,0,8'h00,0,4'd5},  // R5 masked
    '{0,0,1,0,4'd0,0,8'h00,1,8'h80, 3'd1,8'h80,1,0,8'h00,0,4'd2},  // R2 old mask
    '{1,0,0,0,4'd0,0,8'h00,0,8'h00, 3'd0,8'h80,1,0,8'h00,0,4'd2},
    '{1,0,0,0,4'd0,0,8'h00,0,8'h00, 3'd7,8'h80,0,1,8'h05,0,4'd4},  // R4 wrap
    '{0,0,1,0,4'd0,0,8'h00,1,8'h00, 3'd0,8'h00,1,0,8'h00,0,4'd9},
    '{0,0,0,1,4'd5,0,8'h00,0,8'h00, 3'd7,8'h00,0,1,8'h15,0,4'd5},
    '{0,0,1,0,4'd0,0,8'h00,0,8'h00, 3'd0,8'h00,1,0,8'h00,0,4'd9},
    '{0,0,0,0,4'd0,1,8'h2A,0,8'h00, 3'd7,8'h00,0,1,8'h2A,0,4'd6},  // R6
    '{0,0,1,0,4'd0,0,8'h00,0,8'h00, 3'd0,8'h00,1,0,8'h00,0,4'd9},
    '{0,1,0,0,4'd0,0,8'h00,0,8'h00, 3'd1,8'h00,1,0,8'h00,0,4'd2},
    '{0,0,0,0,4'd0,0,8'h00,1,8'h04, 3'd1,8'h04,1,0,8'h00,0,4'd11},
    '{0,1,0,0,4'd0,0,8'h00,0,8'h00, 3'd0,8'h04,0,1,8'h06,0,4'd3},
    '{0,0,1,0,4'd0,0,8'h00,1,8'h00, 3'd1,8'h00,1,0,8'h00,0,4'd9},
    '{1,0,0,1,4'd1,1,8'h33,0,8'h00, 3'd0,8'h00,0,1,8'h33,0,4'd6},
    '{0,0,1,0,4'd0,0,8'h00,0,8'h00, 3'd1,8'h00,1,0,8'h00,0,4'd9},
    '{1,0,0,1,4'd2,0,8'h00,0,8'h00, 3'd0,8'h00,1,0,8'h00,0,4'd6},
    '{0,0,0,1,4'd2,0,8'h00,0,8'h00, 3'd7,8'h00,0,1,8'h12,0,4'd5},
    '{1,0,0,0,4'd0,0,8'h00,0,8'h00, 3'd6,8'h00,0,0,8'h00,0,4'd2},
    '{0,0,0,0,4'd0,1,8'h01,0,8'h00, 3'd6,8'h00,0,0,8'h00,1,4'd7},  // R7
    '{1,0,1,1,4'd9,1,8'h44,0,8'h00, 3'd6,8'h00,0,0,8'h00,1,4'd8},  // R8
    '{0,1,0,0,4'd0,0,8'h00,1,8'hFF, 3'd6,8'h00,0,0,8'h00,1,4'd8}
  };

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic clearIn();
    saveReq = 0; restoreReq = 0; rettReq = 0; irqReq = 0; faultReq = 0;
    maskWrite = 0; irqLevel = 0; faultType = 0; maskData = 0;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic doReset(string req);
    clearIn();
    rst = 1;
    tick();
    tick();
    rst = 0;
    check(req, "win", 32'(curWin), 0);
    check(req, "mask", 32'(invMask), 32'h02);
    check(req, "et", 32'(trapEnable), 0);
    check(req, "halt", 32'(errorHalt), 0);
    check(req, "taken", 32'(trapTaken), 0);
  endtask

  task automatic mapCheck(logic [4:0] r, logic [7:0] exp);
    logReg = r;
    #1;
    check("R10", $sformatf("map r%0d win%0d", r, curWin), 32'(physIdx), 32'(exp));
  endtask

  initial begin
    @(negedge clk);
    doReset("R1");
    for (int i = 0; i < 26; i++) begin
      vec_t v;
      string tag;
      v = TABLE[i];
      tag = $sformatf("R%0d row%0d", v.req, i);
      saveReq = v.sv; restoreReq = v.rs; rettReq = v.rt; irqReq = v.irq;
      irqLevel = v.lvl; faultReq = v.flt; faultType = v.ft;
      maskWrite = v.we; maskData = v.wd;
      tick();
      check(tag, "win", 32'(curWin), 32'(v.eWin));
      check(tag, "mask", 32'(invMask), 32'(v.eMask));
      check(tag, "et", 32'(trapEnable), 32'(v.eEt));
      check(tag, "taken", 32'(trapTaken), 32'(v.eTk));
      check(tag, "halt", 32'(errorHalt), 32'(v.eHalt));
      if (v.eTk) check(tag, "vector", trapVector, {BASE, v.eTt, 4'h0});
    end

    // R8: reset is the only way out of halt; R1 state restored
    doReset("R8");

    // R7: masked restore with traps disabled right after reset
    restoreReq = 1;
    tick();
    clearIn();
    check("R7", "halt", 32'(errorHalt), 1);
    check("R7", "win", 32'(curWin), 0);
    check("R7", "taken", 32'(trapTaken), 0);

    // R10: mapping at window 0 and window 7
    doReset("R1");
    mapCheck(5'd3, 8'd3);
    mapCheck(5'd8, 8'd8);
    mapCheck(5'd16, 8'd16);
    mapCheck(5'd24, 8'd24);
    mapCheck(5'd31, 8'd31);
    maskWrite = 1; maskData = 8'h00; tick(); clearIn();
    rettReq = 1; tick(); clearIn();
    saveReq = 1; tick(); tick(); clearIn();
    check("R2", "win after two saves", 32'(curWin), 7);
    mapCheck(5'd8, 8'd120);
    mapCheck(5'd16, 8'd128);
    mapCheck(5'd24, 8'd8);
    mapCheck(5'd31, 8'd15);
    mapCheck(5'd7, 8'd7);

    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      nTests++;
      nFail++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

endmodule